// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receiving side of a half-duplex synchronous serial link in which the block is the clock master. While reception is enabled, it generates a shift clock from a programmable divider. It samples a single data line on each falling edge of that clock and assembles words of 8 bits, or 9 bits in nine-bit mode. Each finished word, together with its ninth bit, moves into a two-entry receive FIFO.

The host sees the FIFO head and a set of flags. It programs four control bits with one write strobe: single-word receive, continuous receive, nine-bit mode and interrupt enable. It sets the divider value with a second strobe, and it pops the head of the FIFO by pulsing a read strobe. Single-word mode stops after one word. Continuous mode runs until the host clears it. If the FIFO is full when a word completes, an overrun flag is set. That word is lost, and all further transfers into the FIFO stay blocked until the host writes the control register with the continuous bit at 0.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, all control bits are 0, and so are the divider, the shift clock, the data-available flag, the interrupt, the overrun flag and the visible data byte.
- R2: The control write `ctl_we` loads `ctl_wdata` as follows: bit 0 single-word enable, bit 1 continuous enable, bit 2 nine-bit mode, bit 3 interrupt enable. While either receive enable is set, each shift clock level lasts divider+1 system clocks. While neither is set, the shift clock stays low.
- R3: The data line is sampled on each falling edge of the shift clock, and the first bit sampled is the least significant bit of the word.
- R4: In single-word mode, with continuous mode off, exactly one word is received. The single-word enable then clears itself and no further shift clock edges appear.
- R5: In continuous mode, words are received back to back until the continuous enable is cleared. If both enables are set, the block behaves as in continuous mode and the single-word enable stays set.
- R6: Nine-bit mode is sampled at the start of each word. A nine-bit word takes 9 clocks and stores its ninth bit with its data byte. An eight-bit word stores a ninth bit of 0.
- R7: The FIFO holds two words and returns them in arrival order. A third word may shift in while two words are unread.
- R8: If the FIFO is full when the last bit of a word is sampled, the overrun flag is set and that word is discarded.
- R9: While overrun is set, no word enters the FIFO. Only a control write with bit 1 at 0 clears overrun. A write with bit 1 at 1 leaves it set.
- R10: Data-available is set while the FIFO holds a word and drops only when a read empties it. The interrupt is high exactly when data-available and the interrupt enable are both set.
- R11: A read pops the head, so the visible byte and the visible ninth bit both advance to the next entry. A read of an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control bits: single, continuous, nine-bit, interrupt enable |
| div_we | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W | Divider value (half-period = value+1 clocks) |
| rd_pop | input | 1 | Read strobe; pops the FIFO head |
| sdata | input | 1 | Serial data line |
| sclk | output | 1 | Generated shift clock |
| rd_data | output | 8 | Data byte at the FIFO head |
| rd_bit9 | output | 1 | Ninth bit at the FIFO head |
| data_avail | output | 1 | FIFO holds at least one word |
| irq | output | 1 | Receive interrupt |
| overrun | output | 1 | Overrun flag |
| stat_single | output | 1 | Single-word enable status |
| stat_cont | output | 1 | Continuous enable status |
| stat_nine | output | 1 | Nine-bit mode status |
| stat_ien | output | 1 | Interrupt enable status |

## Verification
The hardest state to reach from the ports is a blocked receiver: two unread words, a third word that overflows, and a fourth word arriving while overrun is set. The bench turns off its scoreboard reader and streams four words back to back in continuous mode. It then drains the FIFO by hand to show that only the first two words were kept. It also rewrites the control register, first with the continuous bit kept at 1 and then at 0, to show which write releases the flag. A separate run places two nine-bit words with different ninth bits in the FIFO, so that the ninth bit is seen to advance on a read.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned WORD_W = 8;

  // control write field positions
  localparam int unsigned CTL_SINGLE = 0;
  localparam int unsigned CTL_CONT   = 1;
  localparam int unsigned CTL_NINE   = 2;
  localparam int unsigned CTL_IEN    = 3;
  localparam int unsigned CTL_W      = 4;

  typedef struct packed {
    logic              extra;
    logic [WORD_W-1:0] data;
  } srx_word_t;
endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;

  always_comb begin
    cnt_d    = cnt_q;
    sclk_d   = sclk_q;
    fall_evt = 1'b0;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (cnt_q >= div) begin
      cnt_d    = '0;
      sclk_d   = ~sclk_q;
      fall_evt = sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/srx_shift.sv
module srx_shift
  import srx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      fall_evt,
  input  logic      sdata,
  input  logic      nine_mode,
  output logic      word_done,
  output srx_word_t word_o
);
  localparam int unsigned SH_W  = WORD_W + 1;
  localparam int unsigned IDX_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q, sh_d, merged;
  logic [IDX_W-1:0] idx_q, idx_d, last_idx;
  logic             nine_q, nine_d, eff_nine;

  always_comb begin
    eff_nine  = (idx_q == '0) ? nine_mode : nine_q;
    last_idx  = eff_nine ? IDX_W'(WORD_W) : IDX_W'(WORD_W - 1);
    merged    = sh_q;
    merged[idx_q] = sdata;
    word_done = run && fall_evt && (idx_q == last_idx);
    word_o.data  = merged[WORD_W-1:0];
    word_o.extra = eff_nine & merged[WORD_W];

    sh_d   = sh_q;
    idx_d  = idx_q;
    nine_d = nine_q;
    if (!run) begin
      idx_d = '0;
    end else if (fall_evt) begin
      sh_d = merged;
      if (idx_q == '0) nine_d = nine_mode;
      if (idx_q == last_idx) idx_d = '0;
      else                   idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      nine_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      nine_q <= nine_d;
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [W-1:0]     mem_d [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign head  = mem_q[rd_q];

  always_comb begin
    do_push = push && !full;
    do_pop  = pop && !empty;
    mem_d   = mem_q;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (do_push) begin
      mem_d[wr_q] = din;
      wr_d        = bump(wr_q);
    end
    if (do_pop) rd_d = bump(rd_q);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import srx_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic              rd_pop,
  input  logic              sdata,
  output logic              sclk,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              data_avail,
  output logic              irq,
  output logic              overrun,
  output logic              stat_single,
  output logic              stat_cont,
  output logic              stat_nine,
  output logic              stat_ien
);
  localparam int unsigned ENTRY_W = $bits(srx_word_t);

  logic             single_q, single_d, cont_q, cont_d;
  logic             nine_q, nine_d, ien_q, ien_d;
  logic             ovr_q, ovr_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             run, fall_evt, word_done, fifo_push;
  logic             fifo_empty, fifo_full;
  srx_word_t        rx_word, head_word;

  assign run = single_q | cont_q;

  srx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div      (div_q),
    .sclk     (sclk),
    .fall_evt (fall_evt)
  );

  srx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .fall_evt  (fall_evt),
    .sdata     (sdata),
    .nine_mode (nine_q),
    .word_done (word_done),
    .word_o    (rx_word)
  );

  assign fifo_push = word_done && !ovr_q && !fifo_full;

  srx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   (rx_word),
    .pop   (rd_pop),
    .head  (head_word),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  always_comb begin
    single_d = single_q;
    cont_d   = cont_q;
    nine_d   = nine_q;
    ien_d    = ien_q;
    div_d    = div_q;
    ovr_d    = ovr_q;
    // a single-word reception ends itself unless continuous mode rules
    if (word_done && !cont_q) single_d = 1'b0;
    if (ctl_we) begin
      single_d = ctl_wdata[CTL_SINGLE];
      cont_d   = ctl_wdata[CTL_CONT];
      nine_d   = ctl_wdata[CTL_NINE];
      ien_d    = ctl_wdata[CTL_IEN];
    end
    if (div_we) div_d = div_wdata;
    if (ctl_we && !ctl_wdata[CTL_CONT]) ovr_d = 1'b0;
    else if (word_done && fifo_full)    ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      cont_q   <= 1'b0;
      nine_q   <= 1'b0;
      ien_q    <= 1'b0;
      div_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      single_q <= single_d;
      cont_q   <= cont_d;
      nine_q   <= nine_d;
      ien_q    <= ien_d;
      div_q    <= div_d;
      ovr_q    <= ovr_d;
    end
  end

  assign rd_data     = head_word.data;
  assign rd_bit9     = head_word.extra;
  assign data_avail  = !fifo_empty;
  assign irq         = data_avail & ien_q;
  assign overrun     = ovr_q;
  assign stat_single = single_q;
  assign stat_cont   = cont_q;
  assign stat_nine   = nine_q;
  assign stat_ien    = ien_q;
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_pop,
  input logic sclk,
  input logic data_avail,
  input logic overrun,
  input logic stat_single,
  input logic stat_cont
);
  // R2: the shift clock goes low once reception is off
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_single || stat_cont) |=> !sclk);

  // R2: a rising shift clock edge needs an enabled receiver
  a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(stat_single || stat_cont));

  // R10: data-available drops only after a read
  a_r10_avail_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(rd_pop));

  // R8: overrun rises only when the FIFO held data
  a_r8_ovr_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(data_avail));

  // R9: overrun clears only with continuous mode off
  a_r9_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> !stat_cont);
endmodule

bind sync_rx_master sync_rx_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_pop      (rd_pop),
  .sclk        (sclk),
  .data_avail  (data_avail),
  .overrun     (overrun),
  .stat_single (stat_single),
  .stat_cont   (stat_cont)
);

// File: tb/sync_rx_master_test.sv
module sync_rx_master_test;
  logic       clk, rst_n;
  logic       ctl_we, div_we, sdata;
  logic [3:0] ctl_wdata;
  logic [7:0] div_wdata;
  logic       mon_pop, host_pop, rd_pop;
  logic       sclk, rd_bit9, data_avail, irq, overrun;
  logic       stat_single, stat_cont, stat_nine, stat_ien;
  logic [7:0] rd_data;

  int n_run, n_fail;
  logic mon_on;
  logic [8:0] exp_q[$];

  assign rd_pop = mon_pop | host_pop;

  sync_rx_master uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .rd_pop(rd_pop), .sdata(sdata),
    .sclk(sclk), .rd_data(rd_data), .rd_bit9(rd_bit9), .data_avail(data_avail),
    .irq(irq), .overrun(overrun), .stat_single(stat_single), .stat_cont(stat_cont),
    .stat_nine(stat_nine), .stat_ien(stat_ien)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // control bits: 0 single, 1 continuous, 2 nine-bit, 3 interrupt enable
  task automatic write_ctl(input logic [3:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic write_div(input logic [7:0] v);
    @(negedge clk); div_we = 1'b1; div_wdata = v;
    @(negedge clk); div_we = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); host_pop = 1'b1;
    @(negedge clk); host_pop = 1'b0;
  endtask

  // drives one word LSB first, a new bit after each rising shift clock edge
  task automatic send_word(input logic [8:0] w, input int nbits, input bit expect_it);
    if (expect_it) exp_q.push_back(w);
    for (int i = 0; i < nbits; i++) begin
      @(posedge sclk); #1 sdata = w[i];
    end
    @(negedge sclk);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    check("R3 scoreboard drained", 32'(exp_q.size()), 0);
  endtask

  // scoreboard monitor: reads each available word and compares with the queue
  initial begin
    mon_pop = 1'b0;
    forever begin
      @(negedge clk);
      mon_pop = 1'b0;
      if (mon_on && data_avail) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected word", {23'd0, rd_bit9, rd_data}, 32'h1ff);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check("R3/R6 word and ninth bit", {23'd0, rd_bit9, rd_data}, {23'd0, e});
        end
        mon_pop = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int rises;
    logic prev;
    n_run = 0; n_fail = 0; mon_on = 1'b0;
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; div_we = 1'b0; div_wdata = '0;
    host_pop = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sclk", 32'(sclk), 0);
    check("R1 data_avail", 32'(data_avail), 0);
    check("R1 overrun", 32'(overrun), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 rd_data", 32'(rd_data), 0);
    check("R1 control", {28'd0, stat_ien, stat_nine, stat_cont, stat_single}, 0);

    // R2 half-period equals divider+1
    write_div(8'd3);
    write_ctl(4'b0010);
    @(posedge sclk);
    n = 0;
    do begin @(posedge clk); #1 n++; end while (sclk);
    check("R2 half period", 32'(n), 4);
    write_ctl(4'b0000);
    repeat (2) @(negedge clk);
    check("R2 idle low", 32'(sclk), 0);
    check("R2 status cleared", {30'd0, stat_cont, stat_single}, 0);

    // R3/R4 single 8-bit word
    mon_on = 1'b1;
    write_div(8'd1);
    write_ctl(4'b0001);
    send_word(9'h0a5, 8, 1'b1);
    repeat (4) @(negedge clk);
    check("R4 single clears", 32'(stat_single), 0);
    rises = 0; prev = sclk;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (sclk && !prev) rises++;
      prev = sclk;
    end
    check("R4 no further clocks", 32'(rises), 0);
    wait_drain();

    // R5/R6 continuous nine-bit words
    write_ctl(4'b0110);
    send_word(9'h1c3, 9, 1'b1);
    send_word(9'h03c, 9, 1'b1);
    send_word(9'h155, 9, 1'b1);
    write_ctl(4'b0000);
    wait_drain();

    // R6 eight-bit word after nine-bit words has ninth bit 0
    write_ctl(4'b0001);
    send_word(9'h03c, 8, 1'b1);
    wait_drain();

    // R5 both enables set: continuous
    write_ctl(4'b0011);
    send_word(9'h011, 8, 1'b1);
    send_word(9'h022, 8, 1'b1);
    check("R5 single stays set", 32'(stat_single), 1);
    check("R5 still clocking", 32'(stat_cont), 1);
    write_ctl(4'b0000);
    wait_drain();

    // R7/R8/R9 overrun
    mon_on = 1'b0;
    repeat (4) @(negedge clk);
    write_ctl(4'b0010);
    send_word(9'h001, 8, 1'b0);
    send_word(9'h002, 8, 1'b0);
    send_word(9'h003, 8, 1'b0);
    repeat (2) @(negedge clk);
    check("R8 overrun set", 32'(overrun), 1);
    send_word(9'h004, 8, 1'b0);
    repeat (2) @(negedge clk);
    check("R7 first entry", 32'(rd_data), 32'h01);
    host_read();
    check("R7 second entry", 32'(rd_data), 32'h02);
    host_read();
    check("R9 nothing stored during overrun", 32'(data_avail), 0);
    write_ctl(4'b0010);
    check("R9 overrun kept with cont=1", 32'(overrun), 1);
    write_ctl(4'b0000);
    check("R9 overrun cleared", 32'(overrun), 0);
    repeat (4) @(negedge clk);
    check("R9 no late store", 32'(data_avail), 0);

    // R10 interrupt gating
    write_ctl(4'b0001);
    send_word(9'h05a, 8, 1'b0);
    repeat (2) @(negedge clk);
    check("R10 data available", 32'(data_avail), 1);
    check("R10 irq masked", 32'(irq), 0);
    write_ctl(4'b1000);
    check("R10 irq raised", 32'(irq), 1);
    host_read();
    check("R10 irq drops on empty", 32'(irq), 0);

    // R11 ninth bit advances with the read
    write_ctl(4'b1101);
    send_word(9'h1aa, 9, 1'b0);
    repeat (2) @(negedge clk);
    write_ctl(4'b1101);
    send_word(9'h055, 9, 1'b0);
    repeat (2) @(negedge clk);
    check("R11 head data", 32'(rd_data), 32'haa);
    check("R11 head ninth bit", 32'(rd_bit9), 1);
    host_read();
    check("R10 still available", 32'(data_avail), 1);
    check("R11 next data", 32'(rd_data), 32'h55);
    check("R11 next ninth bit", 32'(rd_bit9), 0);
    host_read();
    check("R10 empty after reads", 32'(data_avail), 0);
    host_read();
    check("R11 empty read no effect", {30'd0, overrun, data_avail}, 0);

    finish_run();
  end
endmodule